// File: doc/BRIEF.md
# Timer Channel Clock Source Selector

This block decides, on every system clock cycle, whether one timer/counter channel should advance. Its output is a count-enable that is high for exactly one system clock cycle per qualifying clock edge, so the counter beside it runs from the system clock alone and never needs a clock of its own.

The channel can count from one of two kinds of source. The first is one of five internal rates, all cut from a single free-running prescaler. The second is one of three external clock lines, each brought into the system clock domain through a two-flop synchroniser and then edge-detected. An invert bit moves counting to the opposite edge of whichever source is chosen. A burst gate can hold counting off whenever a chosen external line, synchronised the same way, is low.

The select inputs are plain control levels. When any of them changes, the output is held low for that cycle, and edge detection starts again from the new source.

Top module: `tcs_clk_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cnt_en` is 0.
- R2: Codes 0, 1, 2, 3 and 4 on `src_sel` choose divisors N = 2, 8, 32, 128 and 1024. A prescaler reads 0 in the first cycle after reset, rises by one each cycle and wraps at 1024. With `inv_en` = 0, `cnt_en` is 1 exactly in the cycles where the prescaler is a multiple of N.
- R3: With an internal code and `inv_en` = 1, `cnt_en` is 1 exactly in the cycles where the prescaler modulo N equals N/2.
- R4: Codes 5, 6 and 7 on `src_sel` choose `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. With `inv_en` = 0, suppose the chosen line is sampled low at system clock edge k-1 and high at edge k. Then `cnt_en` is 1 in the single cycle between edges k+1 and k+2. A falling edge gives no pulse.
- R5: With an external code and `inv_en` = 1, the behaviour of R4 applies to high-to-low changes instead, with the same latency. Rising edges give no pulse.
- R6: `gate_sel` = 0 lets every edge through. Values 1, 2 and 3 gate with `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. The gate line uses the same two-edge synchronising delay as R4, and `cnt_en` is 0 in any cycle where the synchronised gate line is low.
- R7: In any cycle where `src_sel`, `inv_en` or `gate_sel` differs from its value in the previous cycle, `cnt_en` is 0. From the next cycle on, edges are judged only from the new source's levels.
- R8: `cnt_en` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 3 | Count source code (0-4 internal rates, 5-7 external lines) |
| inv_en | input | 1 | Count on the falling edge of the source instead of the rising edge |
| gate_sel | input | 2 | Burst gate line (0 none, 1-3 external line 0-2) |
| ext_clk | input | 3 | Raw external clock lines; each level must last more than one system clock period |
| cnt_en | output | 1 | One-cycle count-enable for the channel |

## Verification
The assertions check four things on every cycle: the quiet cycle after reset, the rule that the output is never high twice in a row, the suppression on a select change, and the gate blocking while its delayed line is low. They also check that every pulse taken from an external line matches a change of the correct polarity on that line, delayed by exactly the synchroniser. The rules that need a long-range count cannot be expressed cycle by cycle, so only the bench's scenarios show them: the exact phase of each internal divisor against the prescaler (including divide-by-1024 across a wrap), the half-period shift under inversion, and re-seeding of the edge history after rapid select churn.

// File: rtl/tcs_pkg.sv
`timescale 1ns/100ps
package tcs_pkg;

  localparam int unsigned N_INT = 5;
  localparam int unsigned PRE_W = 10;

  typedef enum logic [2:0] {
    SRC_DIV2    = 3'd0,
    SRC_DIV8    = 3'd1,
    SRC_DIV32   = 3'd2,
    SRC_DIV128  = 3'd3,
    SRC_DIV1024 = 3'd4,
    SRC_EXT0    = 3'd5,
    SRC_EXT1    = 3'd6,
    SRC_EXT2    = 3'd7
  } tcs_src_e;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_EXT0 = 2'd1,
    GATE_EXT1 = 2'd2,
    GATE_EXT2 = 2'd3
  } tcs_gate_e;

  // log2 of the divisor for each internal rate index
  function automatic int unsigned rate_log2(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 7;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
`timescale 1ns/100ps
module tcs_prescaler #(
  parameter int unsigned CNT_W = tcs_pkg::PRE_W,
  parameter int unsigned N_OUT = tcs_pkg::N_INT
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [N_OUT-1:0] rate_lvl
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  // Square wave per rate; its rising edge falls where the low bits wrap to zero
  for (genvar g = 0; g < N_OUT; g++) begin : g_rate
    localparam int unsigned TOP_BIT = tcs_pkg::rate_log2(g) - 1;
    assign rate_lvl[g] = ~cnt[TOP_BIT];
  end

endmodule

// File: rtl/tcs_sync.sv
`timescale 1ns/100ps
module tcs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/tcs_edge_pick.sv
`timescale 1ns/100ps
module tcs_edge_pick #(
  parameter int unsigned N_INT  = 5,
  parameter int unsigned N_EXT  = 3,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned GSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_lvl,
  input  logic [N_EXT-1:0]  ext_lvl,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              inv_en,
  input  logic [GSEL_W-1:0] gate_sel,
  output logic              pulse
);

  localparam int unsigned N_SRC = N_INT + N_EXT;
  localparam int unsigned CFG_W = SEL_W + 1 + GSEL_W;

  logic [N_SRC-1:0] src_vec;
  logic [N_EXT:0]   gate_vec;
  logic [CFG_W-1:0] cfg, cfg_q;
  logic             sel_lvl, lvl_d, hist_ok, gate_open, cfg_same;

  assign src_vec  = {ext_lvl, int_lvl};
  assign gate_vec = {ext_lvl, 1'b1};     // index 0 means always open
  assign cfg      = {src_sel, inv_en, gate_sel};

  assign sel_lvl   = src_vec[src_sel];
  assign gate_open = gate_vec[gate_sel];
  assign cfg_same  = (cfg == cfg_q);

  // History follows the currently selected source every cycle, so one
  // suppressed cycle after a select change is enough to re-seed it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d   <= 1'b0;
      cfg_q   <= '0;
      hist_ok <= 1'b0;
    end else begin
      lvl_d   <= sel_lvl;
      cfg_q   <= cfg;
      hist_ok <= 1'b1;
    end
  end

  // Edge of the wanted polarity: level changed and now differs from inv_en
  assign pulse = hist_ok & cfg_same & gate_open & (sel_lvl ^ lvl_d) & (sel_lvl ^ inv_en);

endmodule

// File: rtl/tcs_clk_sel.sv
`timescale 1ns/100ps
module tcs_clk_sel #(
  parameter  int unsigned N_EXT       = 3,
  parameter  int unsigned SYNC_STAGES = 2,
  parameter  int unsigned PRE_W       = tcs_pkg::PRE_W,
  localparam int unsigned N_INT       = tcs_pkg::N_INT,
  localparam int unsigned SEL_W       = $clog2(N_INT + N_EXT),
  localparam int unsigned GSEL_W      = $clog2(N_EXT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              inv_en,
  input  logic [GSEL_W-1:0] gate_sel,
  input  logic [N_EXT-1:0]  ext_clk,
  output logic              cnt_en
);

  logic [N_INT-1:0] int_lvl;
  logic [N_EXT-1:0] ext_sync;

  tcs_prescaler #(
    .CNT_W (PRE_W),
    .N_OUT (N_INT)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_lvl (int_lvl)
  );

  tcs_sync #(
    .WIDTH  (N_EXT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_clk),
    .dout  (ext_sync)
  );

  tcs_edge_pick #(
    .N_INT  (N_INT),
    .N_EXT  (N_EXT),
    .SEL_W  (SEL_W),
    .GSEL_W (GSEL_W)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_lvl  (int_lvl),
    .ext_lvl  (ext_sync),
    .src_sel  (src_sel),
    .inv_en   (inv_en),
    .gate_sel (gate_sel),
    .pulse    (cnt_en)
  );

endmodule

// File: rtl/tcs_clk_sel_chk.sv
`timescale 1ns/100ps
module tcs_clk_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] src_sel,
  input logic       inv_en,
  input logic [1:0] gate_sel,
  input logic [2:0] ext_clk,
  input logic       cnt_en
);
  import tcs_pkg::*;

  logic [2:0] live;          // live[i]: i+1 edges seen out of reset
  logic [2:0] e1, e2, e3;    // plain delay line of the raw external lines
  logic [1:0] ext_idx, gate_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else        live <= {live[1:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    e1 <= ext_clk;
    e2 <= e1;
    e3 <= e2;
  end

  assign ext_idx  = 2'(src_sel - SRC_EXT0);
  assign gate_idx = gate_sel - 2'd1;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !live[0] |-> !cnt_en);                                                  // R1

  AST_EXT_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && src_sel >= SRC_EXT0 && live[2]) |->
      (e2[ext_idx] != e3[ext_idx]) && (e2[ext_idx] == !inv_en));            // R4

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (live[1] && gate_sel != GATE_NONE && !e2[gate_idx]) |-> !cnt_en);       // R6

  AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ({src_sel, inv_en, gate_sel} != $past({src_sel, inv_en, gate_sel})) |-> !cnt_en); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> !cnt_en);                                                    // R8

endmodule

bind tcs_clk_sel tcs_clk_sel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_sel  (src_sel),
  .inv_en   (inv_en),
  .gate_sel (gate_sel),
  .ext_clk  (ext_clk),
  .cnt_en   (cnt_en)
);

// File: tb/tb_tcs_clk_sel.sv
`timescale 1ns/100ps
module tb_tcs_clk_sel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_sel;
  logic       inv_en;
  logic [1:0] gate_sel;
  logic [2:0] ext_clk;
  logic       cnt_en;

  always #2.5 clk = ~clk;   // 200 MHz

  tcs_clk_sel dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .inv_en   (inv_en),
    .gate_sel (gate_sel),
    .ext_clk  (ext_clk),
    .cnt_en   (cnt_en)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model state
  int unsigned m_cyc;          // prescaler value per R2
  logic [2:0]  seen [3];       // seen[0] newest edge sample of ext_clk
  bit          primed;
  logic [5:0]  cfg_prev;
  bit          last_en;
  int          hold [3];
  int          divs [5] = '{2, 8, 32, 128, 1024};

  function automatic bit gate_is_open();
    int gi;
    if (gate_sel == 2'd0) return 1'b1;
    gi = int'(gate_sel) - 1;
    return seen[1][gi];
  endfunction

  function automatic bit expect_pulse();
    int b;
    int n;
    if (!rst_n || !primed) return 1'b0;
    if ({src_sel, inv_en, gate_sel} != cfg_prev) return 1'b0;
    if (!gate_is_open()) return 1'b0;
    if (src_sel < 3'd5) begin
      n = divs[src_sel];
      return (int'(m_cyc % n) == (inv_en ? n / 2 : 0));
    end
    b = int'(src_sel) - 5;
    return (seen[1][b] != seen[2][b]) && (seen[1][b] == !inv_en);
  endfunction

  function automatic string req_tag();
    if (!rst_n || !primed) return "R1";
    if ({src_sel, inv_en, gate_sel} != cfg_prev) return "R7";
    if (!gate_is_open()) return "R6";
    if (src_sel < 3'd5) return inv_en ? "R3" : "R2";
    return inv_en ? "R5" : "R4";
  endfunction

  // Called at a falling edge; checks this cycle, then advances the model
  task automatic tick();
    bit exp;
    #1;
    exp = expect_pulse();
    n_chk++;
    if (cnt_en !== exp) begin
      n_fail++;
      $display("FAIL %s: cnt_en=%0b expected %0b (prescaler %0d src %0d inv %0b gate %0d)",
               req_tag(), cnt_en, exp, m_cyc, src_sel, inv_en, gate_sel);
    end
    if (cnt_en === 1'b1) begin
      n_chk++;
      if (last_en) begin
        n_fail++;
        $display("FAIL R8: cnt_en=1 in consecutive cycles, expected 0");
      end
    end
    last_en = (cnt_en === 1'b1);
    @(posedge clk);
    if (!rst_n) begin
      m_cyc = 0; primed = 0; cfg_prev = '0;
      for (int i = 0; i < 3; i++) seen[i] = '0;
    end else begin
      m_cyc++;
      primed   = 1;
      seen[2]  = seen[1];
      seen[1]  = seen[0];
      seen[0]  = ext_clk;
      cfg_prev = {src_sel, inv_en, gate_sel};
    end
    @(negedge clk);
  endtask

  task automatic wiggle();
    for (int i = 0; i < 3; i++) begin
      hold[i]--;
      if (hold[i] <= 0) begin
        ext_clk[i] = ~ext_clk[i];
        hold[i]    = 2 + int'($urandom_range(0, 4));
      end
    end
  endtask

  task automatic run(input int n, input logic [2:0] s, input logic inv,
                     input logic [1:0] g, input bit move);
    src_sel = s; inv_en = inv; gate_sel = g;
    for (int c = 0; c < n; c++) begin
      if (move) wiggle();
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; src_sel = '0; inv_en = 1'b0; gate_sel = '0; ext_clk = '0;
    m_cyc = 0; primed = 0; cfg_prev = '0; last_en = 0;
    for (int i = 0; i < 3; i++) begin seen[i] = '0; hold[i] = 2 + i; end
    @(negedge clk);
    // R1: quiet under reset and in the first cycle after it
    for (int c = 0; c < 4; c++) tick();
    rst_n = 1'b1;
    run(40, 3'd0, 1'b0, 2'd0, 0);
    // R2 / R3: every internal rate, both polarities, across prescaler wraps
    for (int s = 0; s < 5; s++)
      for (int v = 0; v < 2; v++)
        run(2200, 3'(s), 1'(v), 2'd0, 1);
    // R4 / R5: external lines, both polarities
    for (int s = 5; s < 8; s++)
      for (int v = 0; v < 2; v++)
        run(300, 3'(s), 1'(v), 2'd0, 1);
    // R6: burst gating on internal and external sources
    for (int g = 1; g < 4; g++) begin
      run(400, 3'd0, 1'b0, 2'(g), 1);
      run(400, 3'd6, 1'b1, 2'(g), 1);
    end
    // R7: rapid select churn
    for (int k = 0; k < 300; k++)
      run(1 + int'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1);
    // R1 again: reset in mid-run
    rst_n = 1'b0;
    for (int c = 0; c < 3; c++) tick();
    rst_n = 1'b1;
    run(40, 3'd1, 1'b0, 2'd0, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule